// File: doc/BRIEF.md
# Four-Digit Decimal Setpoint Entry

This block sits behind a keypad scanner and turns a series of decimal keystrokes into one binary speed setpoint. Each strobe that carries a digit code from 0 to 9 is taken as the next digit. The digit's place in the series sets its decimal weight. The first digit counts in thousands, the second in hundreds, the third in tens and the fourth in units.

When the fourth digit is taken, the weighted sum appears on the setpoint output, and a valid flag is high for a single clock. The setpoint then holds that value until the next complete entry. A display or a speed loop can latch it on the flag. Codes above 9, such as function keys, are dropped and do not use up a digit position. A clear input abandons a partial entry so that the operator can start again. Clear does not disturb the last completed setpoint.

Top module: `key_setpoint_entry`

## Requirements
- R1: After reset, `setpt_o` is 0 and `setpt_vld_o` is low.
- R2: Counting accepted digits from the start of an entry, the completed setpoint equals 1000*d0 + 100*d1 + 10*d2 + d3, where d0 is the first digit and d3 the fourth.
- R3: `setpt_vld_o` is high for exactly one clock, in the cycle after the clock edge that accepts the fourth digit. It is low after the first, second and third digits.
- R4: `setpt_o` changes only together with a `setpt_vld_o` pulse. Otherwise it keeps the last completed value.
- R5: A strobe whose `key_i` code is 10 to 15 is ignored. It contributes nothing and does not advance the digit position.
- R6: `key_i` has no effect while `key_vld_i` is low.
- R7: While `clr_i` is high at a clock edge, any partial entry is dropped and the next accepted digit is weighted by 1000. A key strobed in that same cycle is discarded. `setpt_o` and its last value are not changed.
- R8: After a completed entry, the next accepted digit starts a new entry, with weight 1000.
- R9: The output is 14 bits wide, and the largest setpoint, 9999 from four 9s, is presented without loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | 4 | Key code from the scanner; 0 to 9 are digits |
| key_vld_i | input | 1 | One-cycle strobe marking `key_i` as a new keypress |
| clr_i | input | 1 | Abandon the partial entry |
| setpt_o | output | 14 | Last completed setpoint |
| setpt_vld_o | output | 1 | One-clock pulse when `setpt_o` takes a new value |

## Verification
Every result lies one register stage behind the edge that takes the fourth digit. The bench drives each key at a falling edge and lets the next rising edge accept it. It reads `setpt_o` and `setpt_vld_o` at the falling edge after that, and then again one cycle later to confirm that the pulse has dropped and the value holds. The same one-cycle spacing covers ignored codes, idle cycles and clear: after each such stimulus the bench looks for an unchanged output. It then finishes a fresh entry, which shows through the ports that the digit position did not move.

// File: rtl/kse_pkg.sv
package kse_pkg;
  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned MAX_DIGIT = 9;

  function automatic int unsigned pow10(input int unsigned n);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction
endpackage

// File: rtl/kse_digit_filter.sv
module kse_digit_filter
  import kse_pkg::*;
(
  input  logic [DIGIT_W-1:0] key_i,
  input  logic               key_vld_i,
  input  logic               clr_i,
  output logic               take_o
);
  logic is_digit;
  assign is_digit = (key_i <= DIGIT_W'(MAX_DIGIT));
  // clear wins over a simultaneous keypress
  assign take_o   = key_vld_i & is_digit & ~clr_i;
endmodule

// File: rtl/kse_pos_ctr.sv
module kse_pos_ctr #(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned POS_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             take_i,
  output logic [POS_W-1:0] pos_o,
  output logic             last_o
);
  logic [POS_W-1:0] pos_q;

  assign last_o = (pos_q == POS_W'(NUM_DIGITS - 1));
  assign pos_o  = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (clr_i)  pos_q <= '0;
    else if (take_i) pos_q <= last_o ? '0 : pos_q + POS_W'(1);
  end

  AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pos_q == '0)); // R7
endmodule

// File: rtl/kse_weight.sv
module kse_weight
  import kse_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  parameter int unsigned SP_W       = 14,
  parameter int unsigned POS_W      = 2
) (
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic [POS_W-1:0]   pos_i,
  output logic [SP_W-1:0]    term_o
);
  localparam int unsigned SLOTS = 2 ** POS_W;

  logic [SP_W-1:0] prod [SLOTS];

  // constant multiply per position; first position carries the highest power
  for (genvar p = 0; p < SLOTS; p++) begin : g_slot
    if (p < NUM_DIGITS) begin : g_used
      assign prod[p] = SP_W'(digit_i) * SP_W'(pow10(NUM_DIGITS - 1 - p));
    end else begin : g_unused
      assign prod[p] = '0;
    end
  end

  assign term_o = prod[pos_i];
endmodule

// File: rtl/kse_accum.sv
module kse_accum #(
  parameter int unsigned SP_W   = 14,
  parameter int unsigned SP_MAX = 9999
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            take_i,
  input  logic            last_i,
  input  logic [SP_W-1:0] term_i,
  output logic [SP_W-1:0] setpt_o,
  output logic            setpt_vld_o
);
  logic [SP_W-1:0] part_q, setpt_q, sum;
  logic            vld_q;

  assign sum = part_q + term_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q  <= '0;
      setpt_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (clr_i) begin
        part_q <= '0;
      end else if (take_i) begin
        if (last_i) begin
          setpt_q <= sum;
          vld_q   <= 1'b1;
          part_q  <= '0;
        end else begin
          part_q  <= sum;
        end
      end
    end
  end

  assign setpt_o     = setpt_q;
  assign setpt_vld_o = vld_q;

  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setpt_vld_o |=> !setpt_vld_o); // R3
  AST_HOLD_SETPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !setpt_vld_o |-> $stable(setpt_o)); // R4
  AST_CLR_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!setpt_vld_o && $stable(setpt_o))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setpt_o <= SP_W'(SP_MAX)); // R9
endmodule

// File: rtl/key_setpoint_entry.sv
module key_setpoint_entry
  import kse_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned SP_W  = $clog2(pow10(NUM_DIGITS)),
  localparam int unsigned POS_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIGIT_W-1:0] key_i,
  input  logic               key_vld_i,
  input  logic               clr_i,
  output logic [SP_W-1:0]    setpt_o,
  output logic               setpt_vld_o
);
  localparam int unsigned SP_MAX = pow10(NUM_DIGITS) - 1;

  logic             take, last;
  logic [POS_W-1:0] pos;
  logic [SP_W-1:0]  term;

  kse_digit_filter i_filter (
    .key_i     (key_i),
    .key_vld_i (key_vld_i),
    .clr_i     (clr_i),
    .take_o    (take)
  );

  kse_pos_ctr #(.NUM_DIGITS(NUM_DIGITS)) i_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .take_i (take),
    .pos_o  (pos),
    .last_o (last)
  );

  kse_weight #(.NUM_DIGITS(NUM_DIGITS), .SP_W(SP_W), .POS_W(POS_W)) i_weight (
    .digit_i (key_i),
    .pos_i   (pos),
    .term_o  (term)
  );

  kse_accum #(.SP_W(SP_W), .SP_MAX(SP_MAX)) i_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .take_i      (take),
    .last_i      (last),
    .term_i      (term),
    .setpt_o     (setpt_o),
    .setpt_vld_o (setpt_vld_o)
  );

  AST_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_vld_i && !clr_i && key_i > DIGIT_W'(MAX_DIGIT)) |=> $stable(pos)); // R5
  AST_IDLE_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_vld_i && !clr_i) |=> $stable(pos)); // R6
  AST_WRAP_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setpt_vld_o |-> (pos == '0)); // R8
endmodule

// File: tb/test_key_setpoint_entry.sv
module test_key_setpoint_entry;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  key_i = '0;
  logic        key_vld_i = 1'b0;
  logic        clr_i = 1'b0;
  logic [13:0] setpt_o;
  logic        setpt_vld_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  key_setpoint_entry i_key_setpoint_entry (
    .clk_i, .rst_ni, .key_i, .key_vld_i, .clr_i, .setpt_o, .setpt_vld_o
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, accepted at next posedge, outputs read at following negedge
  task automatic press(input int code, input bit vld = 1'b1, input bit clr = 1'b0);
    @(negedge clk_i);
    key_i = 4'(code); key_vld_i = vld; clr_i = clr;
    @(negedge clk_i);
    key_vld_i = 1'b0; clr_i = 1'b0; key_i = '0;
  endtask

  task automatic enter4(input int a, input int b, input int c, input int d, input int prev);
    press(a); chk(!setpt_vld_o && setpt_o == 14'(prev), "R3 no pulse after digit 1", setpt_vld_o, 0);
    press(b); chk(!setpt_vld_o && setpt_o == 14'(prev), "R4 hold after digit 2", setpt_o, prev);
    press(c); chk(!setpt_vld_o, "R3 no pulse after digit 3", setpt_vld_o, 0);
    press(d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int prev;
    repeat (3) @(negedge clk_i);
    chk(setpt_o == 0, "R1 setpoint after reset", setpt_o, 0);
    chk(!setpt_vld_o, "R1 valid after reset", setpt_vld_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R3 R4 R8 R9: exhaustive sweep of all four-digit entries, back to back
    prev = 0;
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 10; c++)
          for (int d = 0; d < 10; d++) begin
            int exp;
            exp = a * 1000 + b * 100 + c * 10 + d;
            if (c == 0 && d == 0) begin
              enter4(a, b, c, d, prev);
            end else begin
              press(a); press(b); press(c); press(d);
            end
            chk(setpt_vld_o == 1'b1, "R3 pulse after digit 4", setpt_vld_o, 1);
            chk(setpt_o == 14'(exp), "R2 weighted setpoint", setpt_o, exp);
            prev = exp;
          end
    chk(setpt_o == 14'd9999, "R9 maximum value", setpt_o, 9999);
    @(negedge clk_i);
    chk(!setpt_vld_o, "R3 pulse is one clock", setpt_vld_o, 0);
    chk(setpt_o == 14'd9999, "R4 value holds", setpt_o, 9999);

    // R5: codes 10..15 mid-entry are ignored
    press(1);
    for (int k = 10; k < 16; k++) begin
      press(k);
      chk(!setpt_vld_o && setpt_o == 14'd9999, "R5 non-digit ignored", setpt_o, 9999);
    end
    press(2); press(3); press(4);
    chk(setpt_vld_o && setpt_o == 14'd1234, "R5 position not advanced", setpt_o, 1234);

    // R6: digit codes without strobe ignored
    press(7, 1'b0);
    chk(!setpt_vld_o && setpt_o == 14'd1234, "R6 no strobe no effect", setpt_o, 1234);
    press(5); press(8, 1'b0); press(6); press(9, 1'b0); press(7); press(8);
    chk(setpt_vld_o && setpt_o == 14'd5678, "R6 unstrobed digits skipped", setpt_o, 5678);

    // R7: clear drops partial entry, keeps setpoint
    press(9); press(9); press(0, 1'b0, 1'b1);
    chk(!setpt_vld_o && setpt_o == 14'd5678, "R7 clear keeps setpoint", setpt_o, 5678);
    press(4); press(3); press(2); press(1);
    chk(setpt_vld_o && setpt_o == 14'd4321, "R7 entry restarts after clear", setpt_o, 4321);

    // R7: clear with simultaneous key, the key is discarded
    press(8); press(8); press(8);
    press(8, 1'b1, 1'b1);
    chk(!setpt_vld_o && setpt_o == 14'd4321, "R7 clear beats key", setpt_o, 4321);
    press(0); press(0); press(4); press(2);
    chk(setpt_vld_o && setpt_o == 14'd42, "R7 key with clear dropped", setpt_o, 42);

    // R8: entry right after completion starts at thousands
    press(3); press(0); press(0); press(1);
    chk(setpt_vld_o && setpt_o == 14'd3001, "R8 wrap to first digit", setpt_o, 3001);

    finish_run();
  end
endmodule